// File: doc/BRIEF.md
# Thread-Tagged Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations for a core that runs two hardware threads. Every slot can hold any translation, and each slot records which thread installed it. A lookup presents a virtual address together with a thread ID. All valid slots are compared against the virtual page number and the thread ID in parallel. One clock later the block reports a hit together with the physical address, or it reports a miss. A slot whose page matches but whose thread ID differs never produces a hit, so one thread cannot see another thread's mappings.

An external page walker or a software handler installs translations through a fill port. A fill that repeats an existing page-and-thread pair rewrites that slot in place. Otherwise the fill takes the lowest-numbered empty slot. When the table is full, a rotating victim pointer picks the slot to replace. A flush input empties the whole table in a single cycle when the address space changes. Two running counters of hits and misses let an observer confirm the hit pattern of an access sequence.

Top module: `tlb_tagged`

## Requirements
- R1: `respValid` is high in exactly the cycle after a cycle with `lkReq` high, and low in every other cycle.
- R2: A lookup hits when some valid slot holds the same virtual page number (`lkVaddr[VADDR_W-1:12]`) and the same thread ID. `respPaddr` is then that slot's physical page number concatenated above the untouched low 12 offset bits of `lkVaddr`.
- R3: A lookup that finds no valid slot with both the same page and the same thread ID is a miss. This includes a slot whose page matches but whose thread ID differs. On a miss `respPaddr` is all zeros.
- R4: While `respValid` is high, exactly one of `respHit` and `respMiss` is high. While `respValid` is low, both are low.
- R5: A fill that matches no existing valid slot writes the lowest-numbered invalid slot.
- R6: When all slots are valid, a non-matching fill replaces the slot named by a victim pointer. The pointer starts at slot 0 after reset or flush and advances by one, wrapping after the last slot, only on such a replacement.
- R7: A fill whose page and thread ID equal those of a valid slot overwrites that slot's physical page in place. It creates no duplicate and does not move the victim pointer.
- R8: `flush` invalidates every slot in one cycle and resets the victim pointer to 0. A fill in the same cycle as a flush is dropped.
- R9: A lookup in the same cycle as a fill or a flush is answered from the table contents as they stood before that cycle's update.
- R10: `hitCount` and `missCount` are each incremented by one for every hit or miss response. The new value appears in the same cycle as the response.
- R11: After reset no slot is valid, `respValid`, `respHit` and `respMiss` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkReq | input | 1 | Lookup request strobe |
| lkVaddr | input | VADDR_W | Virtual address to translate |
| lkTid | input | TID_W | Thread ID of the lookup |
| respValid | output | 1 | Lookup result valid (one cycle after request) |
| respHit | output | 1 | Lookup hit |
| respMiss | output | 1 | Lookup miss |
| respPaddr | output | PADDR_W | Translated physical address, zero on miss |
| fillEn | input | 1 | Install a translation |
| fillVpn | input | VADDR_W-12 | Virtual page number to install |
| fillPpn | input | PADDR_W-12 | Physical page number to install |
| fillTid | input | TID_W | Thread that requested the fill |
| flush | input | 1 | Invalidate every slot |
| hitCount | output | CNT_W | Running count of hits |
| missCount | output | CNT_W | Running count of misses |

## Verification
The bench first runs lookups against an empty table and against a single installed translation from both threads. Comparing the two threads separates a correct thread-qualified match from one that checks the page alone. The table is then filled past its capacity, and follow-up lookups show which page was displaced, which tells a rotating victim apart from a fixed or most-recent one. Refills of a page that is already present, then a fill into a full table, show whether in-place update leaves the pointer alone. Lookups that share a cycle with a fill or a flush tell old-contents reads apart from forwarded ones. Back-to-back and idle cycles exercise the response timing.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Widest slot index supported (512 entries).
  localparam int MAX_IDX_W = 9;

  // Strobes from the fill control to the entry datapath.
  typedef struct packed {
    logic                 wrEn;
    logic [MAX_IDX_W-1:0] wrIdx;
    logic                 flushAll;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_low_pick.sv
// Returns the lowest set index of a request vector.
module tlb_low_pick #(
  parameter int W     = 16,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     reqVec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_entry_array.sv
// Slot storage, parallel compare and registered lookup result.
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  parameter int TID_W = 1,
  parameter int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tlbStrobe_t         strobe,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [TID_W-1:0]   fillTid,
  input  logic               lkReq,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [OFF_W-1:0]   lkOff,
  input  logic [TID_W-1:0]   lkTid,
  output logic [N-1:0]       validVec,
  output logic [N-1:0]       fillMatchVec,
  output logic               lkHitNow,
  output logic               respValid,
  output logic               respHit,
  output logic               respMiss,
  output logic [PPN_W+OFF_W-1:0] respPaddr
);
  logic [N-1:0]     validQ;
  logic [VPN_W-1:0] vpnQ [N];
  logic [PPN_W-1:0] ppnQ [N];
  logic [TID_W-1:0] tidQ [N];
  logic [N-1:0]     lkMatch;
  logic [PPN_W-1:0] hitPpn;
  logic [IDX_W-1:0] wrIdxL;
  logic             unusedIdxHi;

  assign wrIdxL      = strobe.wrIdx[IDX_W-1:0];
  assign unusedIdxHi = ^strobe.wrIdx;
  assign validVec    = validQ;

  always_ff @(posedge clk) begin
    if (!rst_n) validQ <= '0;
    else if (strobe.flushAll) validQ <= '0;
    else if (strobe.wrEn) validQ[wrIdxL] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.flushAll) begin
      vpnQ[wrIdxL] <= fillVpn;
      ppnQ[wrIdxL] <= fillPpn;
      tidQ[wrIdxL] <= fillTid;
    end
  end

  // Parallel tag compare, one comparator pair per slot.
  for (genvar g = 0; g < N; g++) begin : gSlot
    assign lkMatch[g]      = validQ[g] && (vpnQ[g] == lkVpn)   && (tidQ[g] == lkTid);
    assign fillMatchVec[g] = validQ[g] && (vpnQ[g] == fillVpn) && (tidQ[g] == fillTid);
  end

  assign lkHitNow = |lkMatch;

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < N; i++) begin
      if (lkMatch[i]) hitPpn = hitPpn | ppnQ[i];
    end
  end

  // Result is registered from pre-update contents (R9).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= lkReq;
      respHit   <= lkReq && lkHitNow;
      respMiss  <= lkReq && !lkHitNow;
      respPaddr <= (lkReq && lkHitNow) ? {hitPpn, lkOff} : '0;
    end
  end

  assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lkReq |=> respValid);
  assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lkReq |=> !respValid);
  assert_outcome_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (respHit ^ respMiss));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !respValid |-> (!respHit && !respMiss));
  assert_miss_no_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    respMiss |-> (respPaddr == '0));
  assert_no_duplicate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkMatch));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flushAll |=> (validQ == '0));
endmodule

// File: rtl/tlb_fill_ctrl.sv
// Fill slot selection, victim pointer, and hit/miss counters.
module tlb_fill_ctrl
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N),
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillEn,
  input  logic             flush,
  input  logic [N-1:0]     validVec,
  input  logic [N-1:0]     fillMatchVec,
  input  logic             lkReq,
  input  logic             lkHitNow,
  output tlbStrobe_t       strobe,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic             freeFound, matchFound, useVictim;
  logic [IDX_W-1:0] freeIdx, matchIdx, pickIdx, victimQ;

  tlb_low_pick #(.W(N), .IDX_W(IDX_W)) u_free (
    .reqVec(~validVec), .found(freeFound), .idx(freeIdx));
  tlb_low_pick #(.W(N), .IDX_W(IDX_W)) u_match (
    .reqVec(fillMatchVec), .found(matchFound), .idx(matchIdx));

  always_comb begin
    useVictim = 1'b0;
    pickIdx   = victimQ;
    if (matchFound)     pickIdx = matchIdx;
    else if (freeFound) pickIdx = freeIdx;
    else                useVictim = fillEn && !flush;
    strobe          = '0;
    strobe.flushAll = flush;
    strobe.wrEn     = fillEn && !flush;
    strobe.wrIdx    = MAX_IDX_W'(pickIdx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) victimQ <= '0;
    else if (useVictim) victimQ <= (victimQ == LAST_IDX) ? '0 : victimQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (lkReq) begin
      if (lkHitNow) hitCount  <= hitCount + 1'b1;
      else          missCount <= missCount + 1'b1;
    end
  end

  assert_fill_free_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && !matchFound && freeFound) |-> !validVec[pickIdx]);
  assert_victim_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    victimQ <= LAST_IDX);
  assert_victim_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fillEn && !flush && matchFound) |=> $stable(victimQ));
  assert_hit_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lkReq && lkHitNow) |=> (hitCount == CNT_W'($past(hitCount) + 1'b1)));
  assert_miss_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lkReq && !lkHitNow) |=> (missCount == CNT_W'($past(missCount) + 1'b1)));
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VADDR_W     = 32,
  parameter int PADDR_W     = 32,
  parameter int TID_W       = 1,
  parameter int CNT_W       = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lkReq,
  input  logic [VADDR_W-1:0]     lkVaddr,
  input  logic [TID_W-1:0]       lkTid,
  output logic                   respValid,
  output logic                   respHit,
  output logic                   respMiss,
  output logic [PADDR_W-1:0]     respPaddr,
  input  logic                   fillEn,
  input  logic [VADDR_W-13:0]    fillVpn,
  input  logic [PADDR_W-13:0]    fillPpn,
  input  logic [TID_W-1:0]       fillTid,
  input  logic                   flush,
  output logic [CNT_W-1:0]       hitCount,
  output logic [CNT_W-1:0]       missCount
);
  localparam int OFF_W = 12;
  localparam int VPN_W = VADDR_W - OFF_W;
  localparam int PPN_W = PADDR_W - OFF_W;
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  tlbStrobe_t       strobe;
  logic [NUM_ENTRIES-1:0] validVec, fillMatchVec;
  logic             lkHitNow;

  tlb_fill_ctrl #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fillEn(fillEn), .flush(flush),
    .validVec(validVec), .fillMatchVec(fillMatchVec),
    .lkReq(lkReq), .lkHitNow(lkHitNow), .strobe(strobe),
    .hitCount(hitCount), .missCount(missCount));

  tlb_entry_array #(.N(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
                    .OFF_W(OFF_W), .TID_W(TID_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillTid(fillTid),
    .lkReq(lkReq), .lkVpn(lkVaddr[VADDR_W-1:OFF_W]), .lkOff(lkVaddr[OFF_W-1:0]),
    .lkTid(lkTid), .validVec(validVec), .fillMatchVec(fillMatchVec),
    .lkHitNow(lkHitNow), .respValid(respValid), .respHit(respHit),
    .respMiss(respMiss), .respPaddr(respPaddr));
endmodule

// File: tb/sim_tlb_tagged.sv
`timescale 1ns/1ps
module sim_tlb_tagged;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkReq = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkTid = 1'b0;
  logic        respValid, respHit, respMiss;
  logic [31:0] respPaddr;
  logic        fillEn = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPpn = '0;
  logic        fillTid = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] hitCount, missCount;

  always #2 clk = ~clk;

  tlb_tagged u0 (
    .clk(clk), .rst_n(rst_n), .lkReq(lkReq), .lkVaddr(lkVaddr), .lkTid(lkTid),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respPaddr(respPaddr), .fillEn(fillEn), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillTid(fillTid), .flush(flush),
    .hitCount(hitCount), .missCount(missCount));

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state.
  bit mValid [N];
  int mVpn [N];
  int mPpn [N];
  int mTid [N];
  int mPtr = 0;
  int mHits = 0;
  int mMisses = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  // One clock: drive, predict from pre-update state, update model, compare.
  task automatic step(input bit req, input logic [31:0] va, input logic tid,
                      input bit fe, input logic [19:0] fv, input logic [19:0] fp,
                      input logic ft, input bit fl, input string tag);
    bit eHit;
    logic [31:0] eAddr;
    int slot;
    @(negedge clk);
    lkReq = req; lkVaddr = va; lkTid = tid;
    fillEn = fe; fillVpn = fv; fillPpn = fp; fillTid = ft; flush = fl;
    eHit = 1'b0;
    eAddr = '0;
    for (int i = 0; i < N; i++) begin
      if (mValid[i] && mVpn[i] == int'(va[31:12]) && mTid[i] == int'(tid)) begin
        eHit = 1'b1;
        eAddr = {mPpn[i][19:0], va[11:0]};
      end
    end
    if (req) begin
      if (eHit) mHits++;
      else mMisses++;
    end
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
      mPtr = 0;
    end else if (fe) begin
      slot = -1;
      for (int i = 0; i < N; i++)
        if (slot < 0 && mValid[i] && mVpn[i] == int'(fv) && mTid[i] == int'(ft)) slot = i;
      if (slot < 0)
        for (int i = 0; i < N; i++)
          if (slot < 0 && !mValid[i]) slot = i;
      if (slot < 0) begin
        slot = mPtr;
        mPtr = (mPtr + 1) % N;
      end
      mValid[slot] = 1'b1;
      mVpn[slot] = int'(fv);
      mPpn[slot] = int'(fp);
      mTid[slot] = int'(ft);
    end
    @(posedge clk);
    #1;
    chk(respValid == req, tag, "respValid", respValid, req);
    chk(respHit == (req && eHit), tag, "respHit", respHit, req && eHit);
    chk(respMiss == (req && !eHit), tag, "respMiss", respMiss, req && !eHit);
    chk(respPaddr == (req ? eAddr : 32'h0), tag, "respPaddr", respPaddr, req ? eAddr : 32'h0);
    chk(int'(hitCount) == mHits, "R10", "hitCount", hitCount, mHits);
    chk(int'(missCount) == mMisses, "R10", "missCount", missCount, mMisses);
  endtask

  task automatic look(input logic [31:0] va, input logic tid, input string tag);
    step(1'b1, va, tid, 1'b0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic fill(input logic [19:0] fv, input logic [19:0] fp, input logic ft,
                      input string tag);
    step(1'b0, '0, 1'b0, 1'b1, fv, fp, ft, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state at the ports.
    chk(respValid == 1'b0, "R11", "respValid", respValid, 0);
    chk(respHit == 1'b0 && respMiss == 1'b0, "R11", "hit/miss", {respHit, respMiss}, 0);
    chk(hitCount == 0 && missCount == 0, "R11", "counters", {hitCount, missCount}, 0);

    look(32'h0010_0ABC, 1'b0, "R11");               // empty table misses
    fill(20'h00100, 20'h0AAAA, 1'b0, "R5");
    look(32'h0010_0123, 1'b0, "R2");                // own thread hits
    look(32'h0010_0123, 1'b1, "R3");                // other thread misses
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R1"); // idle cycle
    // R9: fill and lookup of the same page together see old contents.
    step(1'b1, 32'h0020_0ABC, 1'b1, 1'b1, 20'h00200, 20'h0BBBB, 1'b1, 1'b0, "R9");
    look(32'h0020_0ABC, 1'b1, "R9");
    for (int i = 2; i < N; i++)
      fill(20'h00300 + 20'(i), 20'h05000 + 20'(i), 1'(i), "R5");
    for (int i = 2; i < N; i++)
      look({20'h00300 + 20'(i), 12'h777}, 1'(i), "R2");
    look(32'h0030_3777, 1'b0, "R3");                // page match, wrong thread
    // R6: table full, victims rotate from slot 0.
    fill(20'h07777, 20'h0C001, 1'b0, "R6");
    look(32'h0010_0000, 1'b0, "R6");
    fill(20'h07778, 20'h0C002, 1'b0, "R6");
    look(32'h0020_0FFF, 1'b1, "R6");
    look(32'h0777_7010, 1'b0, "R6");
    // R7: refill of a present page rewrites in place.
    fill(20'h00305, 20'h12345, 1'b1, "R7");
    look(32'h0030_5abc, 1'b1, "R7");
    fill(20'h08888, 20'h0D003, 1'b1, "R7");         // evicts slot 2
    look(32'h0030_2000, 1'b0, "R7");
    look(32'h0030_5001, 1'b1, "R7");
    look(32'h0888_8FFF, 1'b1, "R7");
    // R9 with flush: the same-cycle lookup still hits.
    step(1'b1, 32'h0030_6123, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, "R9");
    look(32'h0030_6123, 1'b0, "R8");
    look(32'h0777_7000, 1'b0, "R8");
    // R8: fill dropped when it meets a flush.
    step(1'b0, '0, 1'b0, 1'b1, 20'h09999, 20'h0E000, 1'b0, 1'b1, "R8");
    look(32'h0999_9000, 1'b0, "R8");
    for (int i = 0; i < N + 2; i++)
      fill(20'h0A000 + 20'(i), 20'h0F000 + 20'(i), 1'b0, "R6");
    for (int i = 0; i < N + 2; i++)
      look({20'h0A000 + 20'(i), 12'h042}, 1'b0, "R6");
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R4");
    summary();
    $finish;
  end
endmodule